// File: doc/BRIEF.md
# PS/2 Device-to-Host Receiver

This block receives the serial stream that a PS/2 keyboard or mouse sends towards the host. It watches the device clock and data lines, which are plain inputs to the chip, and runs entirely on a system clock that is many times faster than the device clock. Both lines are brought into the system clock domain through synchronizer flops. A falling edge of the device clock is found by comparing successive synchronized samples, and on each such edge one bit is taken from the data line.

Each frame carries eleven bits: a low start bit, eight data bits with the least significant bit first, an odd parity bit and a high stop bit. When a frame completes with correct parity and stop bit, the byte appears on a parallel output and a strobe is high for exactly one system clock cycle. Frames that fail either check are dropped silently and the previous byte stays on the output. An optional watchdog returns the receiver to idle when a frame stalls, so a lost edge cannot shift every later byte out of alignment.

Top module: `ps2_dev_rx`

## Requirements
- R1: With both lines idle high, a frame is decoded as start bit 0, eight data bits, parity bit, stop bit 1; the first data bit received appears on `byte_o[0]` and the eighth on `byte_o[7]`.
- R2: Both inputs pass through two synchronizer flops and a bit is taken only on a falling edge of `dev_clk_i`; if `dev_clk_i` goes low just after rising edge N of `clk_i` for the stop bit of a valid frame, `byte_vld_o` is high in the cycle that follows rising edge N+3. The block has no output towards the device lines.
- R3: `byte_vld_o` is high for exactly one `clk_i` cycle for each valid frame and low otherwise.
- R4: Parity is odd: the eight data bits plus the parity bit must hold an odd number of ones; otherwise no strobe is raised and `byte_o` keeps its previous value.
- R5: A stop bit sampled as 0 drops the frame: no strobe, `byte_o` unchanged.
- R6: A falling edge seen while idle with the data line at 1 is ignored as a glitch; no bit is stored, and a proper frame that starts on the very next edge decodes correctly.
- R7: `byte_o` changes only in the cycle in which `byte_vld_o` is high and holds its value until the next valid frame.
- R8: Driving `rst_ni` low clears `byte_o` to 0, `byte_vld_o` to 0 and the frame state to idle at once; release takes effect two `clk_i` edges later, and a frame sent after a reset that cut an earlier frame decodes correctly.
- R9: With the watchdog enabled (`WDOG_EN` = 1), once inside a frame, if two successive device clock falling edges are WDOG_CYCLES+1 or more system cycles apart, the frame is abandoned and the later edge is treated as a possible start bit; a gap of exactly WDOG_CYCLES keeps the frame alive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, several times faster than the device clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dev_clk_i | input | 1 | PS/2 clock line from the device, idle high |
| dev_dat_i | input | 1 | PS/2 data line from the device, idle high |
| byte_vld_o | output | 1 | One-cycle strobe: a valid byte has been received |
| byte_o | output | DATA_W | Last valid byte received, held between strobes |

## Verification
The two functions that can land in the same cycle are the watchdog expiry and the detection of a device clock falling edge; the design gives the edge priority, so the frame continues. The bench provokes this by stretching one bit inside a frame so that the falling-edge gap is exactly WDOG_CYCLES, and judges it by the byte arriving intact with its strobe in the predicted cycle. The neighbouring case, a gap of WDOG_CYCLES+1 whose edge carries the start bit of a new frame, must instead abandon the old frame and decode the new one, which pins the expiry to a single cycle from both sides.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

  // Frame assembly phases
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_PAR  = 2'd2,
    RX_STOP = 2'd3
  } rx_phase_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned RST_STAGES  = 2;

endpackage

// File: rtl/ps2_rx_rstsync.sv
module ps2_rx_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);

  logic [STAGES-1:0] chain_q;

  // Assert asynchronously, release after STAGES rising edges
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_no = chain_q[STAGES-1];

endmodule

// File: rtl/ps2_rx_sync.sv
module ps2_rx_sync #(
  parameter int unsigned     WIDTH   = 2,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ps2_rx_edge.sv
module ps2_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);

  logic prev_q;

  // Idle level is high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= lvl_i;
    end
  end

  assign fall_o = prev_q & ~lvl_i;

endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
  import ps2_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter bit          WDOG_EN     = 1'b1,
  parameter int unsigned WDOG_CYCLES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              dat_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              busy_o
);

  localparam int unsigned          BCW      = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BCW-1:0]       LAST_BIT = BCW'(DATA_W - 1);

  rx_phase_e          phase_q, phase_d;
  logic [DATA_W-1:0]  shift_q, shift_d;
  logic [BCW-1:0]     bitcnt_q, bitcnt_d;
  logic               par_q, par_d;
  logic [DATA_W-1:0]  out_q, out_d;
  logic               vld_q, vld_d;
  logic               timeout;
  logic               step_en;
  logic               out_en;

  assign busy_o = (phase_q != RX_IDLE);

  // Optional stall watchdog
  if (WDOG_EN) begin : g_wdog
    localparam int unsigned      WDW     = $clog2(WDOG_CYCLES + 1);
    localparam logic [WDW-1:0]   WD_LAST = WDW'(WDOG_CYCLES - 1);
    logic [WDW-1:0] wd_q, wd_d;

    always_comb begin
      if (fall_i || !busy_o) begin
        wd_d = '0;
      end else if (wd_q != WD_LAST) begin
        wd_d = wd_q + 1'b1;
      end else begin
        wd_d = wd_q;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wd_q <= '0;
      end else begin
        wd_q <= wd_d;
      end
    end

    // An edge in the expiry cycle takes priority
    assign timeout = busy_o && !fall_i && (wd_q == WD_LAST);
  end else begin : g_no_wdog
    assign timeout = 1'b0;
  end

  // Next-state logic
  always_comb begin
    phase_d  = phase_q;
    shift_d  = shift_q;
    bitcnt_d = bitcnt_q;
    par_d    = par_q;
    out_d    = out_q;
    vld_d    = 1'b0;
    if (timeout) begin
      phase_d = RX_IDLE;
    end else if (fall_i) begin
      unique case (phase_q)
        RX_IDLE: begin
          if (!dat_i) begin
            phase_d  = RX_DATA;
            bitcnt_d = '0;
            shift_d  = '0;
          end
        end
        RX_DATA: begin
          shift_d  = {dat_i, shift_q[DATA_W-1:1]};
          bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == LAST_BIT) begin
            phase_d = RX_PAR;
          end
        end
        RX_PAR: begin
          par_d   = dat_i;
          phase_d = RX_STOP;
        end
        RX_STOP: begin
          phase_d = RX_IDLE;
          if (dat_i && (^{shift_q, par_q})) begin
            vld_d = 1'b1;
            out_d = shift_q;
          end
        end
        default: phase_d = RX_IDLE;
      endcase
    end
  end

  assign step_en = fall_i | timeout;
  assign out_en  = vld_d;

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= RX_IDLE;
      shift_q  <= '0;
      bitcnt_q <= '0;
      par_q    <= 1'b0;
    end else if (step_en) begin
      phase_q  <= phase_d;
      shift_q  <= shift_d;
      bitcnt_q <= bitcnt_d;
      par_q    <= par_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign vld_o  = vld_q;
  assign byte_o = out_q;

endmodule

// File: rtl/ps2_dev_rx.sv
module ps2_dev_rx
  import ps2_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter bit          WDOG_EN     = 1'b1,
  parameter int unsigned WDOG_CYCLES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_clk_i,
  input  logic              dev_dat_i,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o
);

  logic       rst_int_n;
  logic [1:0] line_s;
  logic       dev_fall;
  logic       frame_busy;

  ps2_rx_rstsync #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (rst_int_n)
  );

  // bit 1: device clock, bit 0: device data
  ps2_rx_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b11)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .d_i    ({dev_clk_i, dev_dat_i}),
    .q_o    (line_s)
  );

  ps2_rx_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .lvl_i  (line_s[1]),
    .fall_o (dev_fall)
  );

  ps2_rx_frame #(
    .DATA_W      (DATA_W),
    .WDOG_EN     (WDOG_EN),
    .WDOG_CYCLES (WDOG_CYCLES)
  ) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .fall_i (dev_fall),
    .dat_i  (line_s[0]),
    .vld_o  (byte_vld_o),
    .byte_o (byte_o),
    .busy_o (frame_busy)
  );

endmodule

// File: rtl/ps2_dev_rx_chk.sv
module ps2_dev_rx_chk #(
  parameter int unsigned DATA_W      = 8,
  parameter bit          WDOG_EN     = 1'b1,
  parameter int unsigned WDOG_CYCLES = 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_vld_o,
  input logic [DATA_W-1:0] byte_o,
  input logic              dev_fall,
  input logic              frame_busy
);

  // R2: a strobe always follows a detected device clock falling edge
  a_r2_strobe_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(dev_fall));

  // R3: strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  // R7: byte output moves only with the strobe
  a_r7_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> $stable(byte_o));

  // R1: a frame only begins on a device clock falling edge
  a_r1_start_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_busy) |-> $past(dev_fall));

  if (WDOG_EN) begin : g_wdog_chk
    localparam int unsigned GW = $clog2(WDOG_CYCLES + 1);
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gap_q <= '0;
      end else if (dev_fall) begin
        gap_q <= '0;
      end else if (gap_q != GW'(WDOG_CYCLES)) begin
        gap_q <= gap_q + 1'b1;
      end
    end

    // R9: a stalled frame has been dropped once the gap exceeds the limit
    a_r9_wdog_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gap_q == GW'(WDOG_CYCLES)) |-> !frame_busy);
  end

endmodule

bind ps2_dev_rx ps2_dev_rx_chk #(
  .DATA_W      (DATA_W),
  .WDOG_EN     (WDOG_EN),
  .WDOG_CYCLES (WDOG_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .byte_vld_o (byte_vld_o),
  .byte_o     (byte_o),
  .dev_fall   (dev_fall),
  .frame_busy (frame_busy)
);

// File: tb/ps2_dev_rx_tb_top.sv
module ps2_dev_rx_tb_top;

  localparam int LIM  = 100;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       dclk = 1'b1;
  logic       dat = 1'b1;
  logic       vld;
  logic [7:0] bout;

  int    cyc = 0;
  int    vectors = 0;
  int    fails = 0;
  string cur_req = "R8";

  typedef struct {
    int         at;
    logic [7:0] b;
  } exp_t;
  exp_t       exp_q[$];
  logic       exp_vld = 1'b0;
  logic [7:0] exp_byte = 8'h00;

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  ps2_dev_rx #(
    .DATA_W      (8),
    .WDOG_EN     (1'b1),
    .WDOG_CYCLES (LIM)
  ) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .dev_clk_i  (dclk),
    .dev_dat_i  (dat),
    .byte_vld_o (vld),
    .byte_o     (bout)
  );

  // Reference model, compared every cycle at the falling clock edge
  always @(negedge clk) begin
    if (!rst_ni) begin
      exp_vld  = 1'b0;
      exp_byte = 8'h00;
      exp_q.delete();
    end else begin
      exp_vld = 1'b0;
      if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
        exp_vld  = 1'b1;
        exp_byte = exp_q[0].b;
        void'(exp_q.pop_front());
      end
    end
    vectors++;
    if (vld !== exp_vld || bout !== exp_byte) begin
      fails++;
      $display("FAIL %s cycle %0d: vld=%0b exp %0b, byte=%02h exp %02h",
               cur_req, cyc, vld, exp_vld, bout, exp_byte);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic dev_bit(input logic b, input int pre);
    dat = b;
    repeat (pre) tick();
    dclk = 1'b0;
    repeat (HALF) tick();
    dclk = 1'b1;
  endtask

  // Full frame; parity odd over data plus parity bit
  task automatic send_frame(input logic [7:0] b, input logic par_flip, input logic stop_v,
                            input int first_pre, input int stall_idx, input int stall_pre);
    logic [10:0] f;
    f[0]   = 1'b0;
    f[8:1] = b;
    f[9]   = (~^b) ^ par_flip;
    f[10]  = stop_v;
    for (int i = 0; i < 11; i++) begin
      int pre;
      pre = (i == 0) ? first_pre : ((i == stall_idx) ? stall_pre : HALF);
      dat = f[i];
      repeat (pre) tick();
      dclk = 1'b0;
      if (i == 10 && !par_flip && stop_v) begin
        exp_t e;
        e.at = cyc + 3;
        e.b  = b;
        exp_q.push_back(e);
      end
      repeat (HALF) tick();
      dclk = 1'b1;
    end
    dat = 1'b1;
  endtask

  task automatic good_frame(input string tag, input logic [7:0] b);
    cur_req = tag;
    send_frame(b, 1'b0, 1'b1, HALF, -1, HALF);
    check(tag, {24'h0, bout}, {24'h0, b});
    repeat (20) tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    #1 rst_ni = 1'b0;
    repeat (3) tick();
    // R8: reset state
    check("R8", {31'h0, vld}, 32'h0);
    check("R8", {24'h0, bout}, 32'h0);
    rst_ni = 1'b1;
    repeat (10) tick();

    // R1: bit order and general decoding
    good_frame("R1", 8'h01);
    good_frame("R1", 8'h80);
    good_frame("R1", 8'h3C);
    good_frame("R3", 8'hFF);
    good_frame("R3", 8'h00);
    // R2: strobe latency judged by the per-cycle model, back-to-back frames
    cur_req = "R2";
    send_frame(8'h96, 1'b0, 1'b1, HALF, -1, HALF);
    send_frame(8'h7E, 1'b0, 1'b1, HALF, -1, HALF);
    check("R2", {24'h0, bout}, 32'h7E);
    repeat (20) tick();

    // R4: bad parity dropped
    cur_req = "R4";
    send_frame(8'h5A, 1'b1, 1'b1, HALF, -1, HALF);
    repeat (10) tick();
    check("R4", {24'h0, bout}, 32'h7E);

    // R5: bad stop bit dropped
    cur_req = "R5";
    send_frame(8'hC3, 1'b0, 1'b0, HALF, -1, HALF);
    repeat (10) tick();
    check("R5", {24'h0, bout}, 32'h7E);
    check("R7", {31'h0, vld}, 32'h0);

    // R6: glitch start then a frame on the next edge
    cur_req = "R6";
    dev_bit(1'b1, HALF);
    good_frame("R6", 8'h81);

    // R9: gap of exactly LIM keeps the frame
    cur_req = "R9";
    send_frame(8'h5C, 1'b0, 1'b1, HALF, 5, LIM - HALF);
    check("R9", {24'h0, bout}, 32'h5C);
    repeat (20) tick();

    // R9: stalled partial frame, next start at gap LIM+1
    dev_bit(1'b0, HALF);
    dev_bit(1'b1, HALF);
    dev_bit(1'b0, HALF);
    send_frame(8'hE7, 1'b0, 1'b1, LIM + 1 - HALF, -1, HALF);
    check("R9", {24'h0, bout}, 32'hE7);
    repeat (20) tick();

    // R7: hold over idle time
    cur_req = "R7";
    repeat (300) tick();
    check("R7", {24'h0, bout}, 32'hE7);

    // R8: reset in the middle of a frame
    cur_req = "R8";
    dev_bit(1'b0, HALF);
    dev_bit(1'b1, HALF);
    dev_bit(1'b1, HALF);
    dev_bit(1'b0, HALF);
    dat = 1'b1;
    rst_ni = 1'b0;
    repeat (3) tick();
    check("R8", {24'h0, bout}, 32'h0);
    rst_ni = 1'b1;
    repeat (10) tick();
    good_frame("R8", 8'h42);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule